// File: doc/BRIEF.md
# Stepped power-down clock post-divider

This block turns a fast oscillator clock into a slower output clock with an even duty cycle. A two-bit ratio code picks one of four ratios. A power-down request adds a further divide-by-16. That extra factor is not switched in one jump: a slow reference clock ramps it through the factors 2, 4, 8 and 16, and back down through the same factors in reverse. An enable input can park the output low without ever cutting a pulse short.

The fast input `clk2x` runs at twice the oscillator rate. Every output edge then comes straight from a register on a `clk2x` edge, and ratio 1 still has an even duty cycle. A ratio R means the output stays high for R `clk2x` cycles and low for R `clk2x` cycles, which is a period of R oscillator cycles. The ramp level is stepped in the reference domain, crossed into the fast domain in Gray code, and added to the exponent that the ratio code selects. A new exponent is taken up only at the end of a low half. Each output period, measured from one rising edge to the next, therefore uses a single ratio.

Top module: `pdiv_stepped`

## Requirements
- R1: While `rst_vco` is high, and in the first cycle after it is released, `fout` is 0.
- R2: With no power-down, `n_code` selects the ratio R: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1. `fout` is high for R and low for R `clk2x` cycles.
- R3: Every completed output period has a high time equal to its low time.
- R4: Once the power-down ramp has settled, the ratio is 16 times the `n_code` ratio: 32, 64, 128 or 16.
- R5: After `pd_req` rises, the ratio passes through 2x, 4x, 8x and 16x of the base ratio in that order. The ramp level moves by exactly one per step, and each level is held for STEP_CYCLES reference cycles.
- R6: After `pd_req` falls, the ratio passes back through 8x, 4x and 2x to the base ratio, one level per STEP_CYCLES reference cycles.
- R7: The first ramp step takes effect no earlier than STEP_CYCLES reference cycles after `pd_req` is sampled, and it shows at the output within a few output periods after that.
- R8: When `out_en` goes low, a high pulse already in progress completes at full width. `fout` then stays 0 for as long as `out_en` stays low.
- R9: When `out_en` returns high, the first pulse is preceded by a low time of at least R and is itself exactly R wide.
- R10: A change of `n_code` or of the ramp level is taken up only at the end of a low half of `fout`. The half-period counter restarts from zero there.
- R11: If `pd_req` is reversed partway through a ramp, the ramp turns back from the level it has reached, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the oscillator rate |
| rst_vco | input | 1 | Synchronous active-high reset for the fast domain |
| ref_clk | input | 1 | Reference clock that paces the power-down ramp |
| rst_ref | input | 1 | Synchronous active-high reset for the reference domain |
| n_code | input | 2 | Base ratio code, quasi-static and synchronous to `clk2x` |
| pd_req | input | 1 | Power-down request, synchronous to `ref_clk` |
| out_en | input | 1 | Output enable, asynchronous, resynchronised inside |
| fout | output | 1 | Divided output clock, registered |

## Verification
The end of a low half is where two separate functions meet. There the divider takes up a new ratio, and it also decides from the synchronised enable whether to rise. The bench re-enables the output while the ratio logic keeps loading at every low boundary. It then judges the first rising pulse by its full preceding low time and its exact width. A second collision comes from dropping `pd_req` while the pacing counter is halfway to the next step. The ramp must then reverse from its current level, and the bench checks that the output passes through the ratio sequence 4, 8, 16, 8, 4 with no value skipped or repeated out of order.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // exponent range contributed by the base ratio code (ratio 1..8)
  localparam int NEXP_MAX = 3;

  typedef enum logic [1:0] {
    NC_DIV2 = 2'b00,
    NC_DIV4 = 2'b01,
    NC_DIV8 = 2'b10,
    NC_DIV1 = 2'b11
  } ncode_e;

  // log2 of the base ratio selected by the code
  function automatic logic [1:0] ncode_exp(input logic [1:0] code);
    case (ncode_e'(code))
      NC_DIV2: return 2'd1;
      NC_DIV4: return 2'd2;
      NC_DIV8: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pdiv_ramp.sv
// Power-down ramp sequencer, reference clock domain.
// Moves a level between 0 and LEVELS one step at a time, one step per
// STEP_CYCLES reference cycles, and publishes it in Gray code for the
// fast domain.
module pdiv_ramp #(
  parameter int LEVELS      = 4,
  parameter int STEP_CYCLES = 16,
  parameter int LVL_W       = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_req,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_gray
);

  localparam int PACE_W = $clog2(STEP_CYCLES + 1);

  logic [LVL_W-1:0]  target;
  logic [PACE_W-1:0] pace;

  assign target = pd_req ? LVL_W'(LEVELS) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      level      <= '0;
      pace       <= '0;
      level_gray <= '0;
    end else begin
      // registered Gray copy: only one bit moves per step
      level_gray <= level ^ (level >> 1);
      if (level == target) begin
        pace <= '0;
      end else if (pace == PACE_W'(STEP_CYCLES - 1)) begin
        pace <= '0;
        if (level < target) level <= level + LVL_W'(1);
        else                level <= level - LVL_W'(1);
      end else begin
        pace <= pace + PACE_W'(1);
      end
    end
  end

endmodule

// File: rtl/pdiv_sync.sv
// Multi-stage synchroniser for slowly changing, single-bit-change data.
module pdiv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/pdiv_core.sv
// Fast-domain divider. Half period = 2**cur_exp cycles of clk.
// The exponent is reloaded only at the end of a low half.
module pdiv_core #(
  parameter int LEVELS = 4,
  parameter int LVL_W  = $clog2(LEVELS + 1),
  parameter int EXP_W  = $clog2(pdiv_pkg::NEXP_MAX + LEVELS + 1),
  parameter int CNT_W  = pdiv_pkg::NEXP_MAX + LEVELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       n_code,
  input  logic [LVL_W-1:0] level_gray_s,
  input  logic             oe_s,
  output logic             fout,
  output logic [EXP_W-1:0] cur_exp
);

  logic [LVL_W-1:0] lvl_bin;
  logic [EXP_W-1:0] tgt_exp;
  logic [CNT_W:0]   half;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] cnt;
  logic             boundary;

  // Gray to binary
  always_comb begin
    lvl_bin[LVL_W-1] = level_gray_s[LVL_W-1];
    for (int i = LVL_W - 2; i >= 0; i--) begin
      lvl_bin[i] = lvl_bin[i+1] ^ level_gray_s[i];
    end
  end

  assign tgt_exp  = EXP_W'(pdiv_pkg::ncode_exp(n_code)) + EXP_W'(lvl_bin);
  assign half     = (CNT_W+1)'(1) << cur_exp;
  assign half_m1  = CNT_W'(half - (CNT_W+1)'(1));
  assign boundary = (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fout    <= 1'b0;
      cur_exp <= tgt_exp;
    end else if (boundary) begin
      cnt <= '0;
      if (fout) begin
        fout <= 1'b0;
      end else begin
        // end of a low half: safe point for a new ratio and for enable
        fout    <= oe_s;
        cur_exp <= tgt_exp;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pdiv_stepped.sv
module pdiv_stepped #(
  parameter int LEVELS      = 4,
  parameter int STEP_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk2x,
  input  logic       rst_vco,
  input  logic       ref_clk,
  input  logic       rst_ref,
  input  logic [1:0] n_code,
  input  logic       pd_req,
  input  logic       out_en,
  output logic       fout
);

  localparam int LVL_W = $clog2(LEVELS + 1);
  localparam int EXP_W = $clog2(pdiv_pkg::NEXP_MAX + LEVELS + 1);
  localparam int CNT_W = pdiv_pkg::NEXP_MAX + LEVELS;

  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] level_gray;
  logic [LVL_W-1:0] level_gray_s;
  logic             oe_s;
  logic [EXP_W-1:0] cur_exp;

  pdiv_ramp #(
    .LEVELS(LEVELS), .STEP_CYCLES(STEP_CYCLES), .LVL_W(LVL_W)
  ) u_ramp (
    .clk(ref_clk), .rst(rst_ref), .pd_req(pd_req),
    .level(level), .level_gray(level_gray)
  );

  pdiv_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk(clk2x), .rst(rst_vco), .din(level_gray), .dout(level_gray_s)
  );

  pdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_oe_sync (
    .clk(clk2x), .rst(rst_vco), .din(out_en), .dout(oe_s)
  );

  pdiv_core #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .EXP_W(EXP_W), .CNT_W(CNT_W)
  ) u_core (
    .clk(clk2x), .rst(rst_vco), .n_code(n_code),
    .level_gray_s(level_gray_s), .oe_s(oe_s),
    .fout(fout), .cur_exp(cur_exp)
  );

endmodule

// File: rtl/pdiv_stepped_chk.sv
module pdiv_stepped_chk #(
  parameter int LEVELS = 4,
  parameter int LVL_W  = 3,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = 7
) (
  input logic             clk2x,
  input logic             rst_vco,
  input logic             ref_clk,
  input logic             rst_ref,
  input logic             out_en,
  input logic             fout,
  input logic [LVL_W-1:0] level,
  input logic [EXP_W-1:0] cur_exp
);

  logic [CNT_W:0] hi_run;

  always_ff @(posedge clk2x) begin
    if (rst_vco)   hi_run <= '0;
    else if (fout) hi_run <= hi_run + (CNT_W+1)'(1);
    else           hi_run <= '0;
  end

  // R1
  fout_reset_chk: assert property (@(posedge clk2x) disable iff (rst_vco)
    $fell(rst_vco) |-> !fout);

  // R3
  high_width_chk: assert property (@(posedge clk2x) disable iff (rst_vco)
    $fell(fout) |-> (hi_run == ((CNT_W+1)'(1) << cur_exp)));

  // R5
  level_step_chk: assert property (@(posedge ref_clk) disable iff (rst_ref)
    !$stable(level) |-> ((level == $past(level) + LVL_W'(1)) ||
                         ($past(level) == level + LVL_W'(1))));

  // R4
  level_range_chk: assert property (@(posedge ref_clk) disable iff (rst_ref)
    level <= LVL_W'(LEVELS));

  // R8 (window sized for the default two synchroniser stages)
  oe_hold_chk: assert property (@(posedge clk2x) disable iff (rst_vco)
    (!out_en && !$past(out_en) && !$past(out_en, 2) && !$past(out_en, 3))
      |-> !$rose(fout));

  // R10
  exp_change_chk: assert property (@(posedge clk2x) disable iff (rst_vco)
    !$stable(cur_exp) |-> !$past(fout));

endmodule

bind pdiv_stepped pdiv_stepped_chk #(
  .LEVELS(LEVELS), .LVL_W(LVL_W), .EXP_W(EXP_W), .CNT_W(CNT_W)
) u_chk (
  .clk2x(clk2x), .rst_vco(rst_vco), .ref_clk(ref_clk), .rst_ref(rst_ref),
  .out_en(out_en), .fout(fout), .level(level), .cur_exp(cur_exp)
);

// File: tb/sim_pdiv_stepped.sv
module sim_pdiv_stepped;

  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 40;
  localparam int STEP       = 128;
  localparam int WATCHDOG   = 150000;
  localparam int RAMP_WAIT  = 4 * STEP * (REF_PERIOD / CLK_PERIOD) + 800;

  logic       clk2x   = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_vco = 1'b1;
  logic       rst_ref = 1'b1;
  logic [1:0] n_code  = 2'b00;
  logic       pd_req  = 1'b0;
  logic       out_en  = 1'b1;
  logic       fout;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;
  initial begin
    #3;
    forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
  end

  pdiv_stepped #(.LEVELS(4), .STEP_CYCLES(STEP), .SYNC_STAGES(2)) u0 (
    .clk2x(clk2x), .rst_vco(rst_vco), .ref_clk(ref_clk), .rst_ref(rst_ref),
    .n_code(n_code), .pd_req(pd_req), .out_en(out_en), .fout(fout)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    exp_q[$];
  int    mode = 0;          // 0 off, 1 full period check, 2 high-only check
  string cur_req = "R2";
  int    run = 0, hi_len = 0, lo_len = 0, rises = 0;
  logic  prev = 1'b0;
  bit    finished = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard: observed high width must be the head or the next item
  task automatic match_high(int h);
    vectors++;
    if (exp_q.size() == 0) begin
      miscompares++;
      $display("FAIL %s high width with empty queue: actual %0d expected none", cur_req, h);
    end else if (h == exp_q[0]) begin
      // same ratio still in force
    end else if (exp_q.size() > 1 && h == exp_q[1]) begin
      void'(exp_q.pop_front());
    end else begin
      miscompares++;
      $display("FAIL %s high width: actual %0d expected %0d", cur_req, h, exp_q[0]);
    end
  endtask

  // monitor, sampling away from the active edge
  always @(negedge clk2x) begin
    if (rst_vco) begin
      run = 0; prev = 1'b0; hi_len = 0;
    end else if (fout === prev) begin
      run++;
    end else begin
      if (prev) begin
        hi_len = run;
        if (mode != 0) match_high(hi_len);
      end else begin
        lo_len = run;
        rises++;
        if (mode == 1 && hi_len > 0) begin
          check("R3", "low half vs high half", lo_len, hi_len);
        end else if (mode == 2 && hi_len > 0 && exp_q.size() > 0) begin
          vectors++;
          if (lo_len < exp_q[0]) begin
            miscompares++;
            $display("FAIL R9 low before pulse: actual %0d expected >= %0d", lo_len, exp_q[0]);
          end
        end
      end
      run  = 1;
      prev = fout;
    end
  end

  task automatic clk(int n);
    repeat (n) @(posedge clk2x);
  endtask

  task automatic set_code(logic [1:0] code, int ratio, int old);
    clk(1);
    exp_q = '{old, ratio};
    @(negedge clk2x) n_code = code;
    clk(2 * 256 + 100);
    check(cur_req, "queue settled", exp_q.size(), 1);
    check(cur_req, "final ratio", exp_q[0], ratio);
  endtask

  task automatic drive_pd(logic v);
    @(negedge ref_clk) pd_req = v;
  endtask

  initial begin
    int r0;
    clk(10);
    @(negedge clk2x);
    check("R1", "fout in reset", int'(fout), 0);
    rst_vco = 1'b0;
    rst_ref = 1'b0;
    @(negedge clk2x);
    check("R1", "fout after release", int'(fout), 0);

    // R2 / R10: every code, switched on the fly
    clk(1);
    exp_q = '{2};
    mode = 1;
    cur_req = "R2";
    clk(300);
    check("R2", "code 00 ratio", exp_q.size(), 1);
    set_code(2'b01, 4, 2);
    set_code(2'b10, 8, 4);
    cur_req = "R10";
    set_code(2'b11, 1, 8);
    cur_req = "R2";
    set_code(2'b00, 2, 1);

    // R7 / R5 / R4: power-down entry from ratio 2
    cur_req = "R5";
    exp_q = '{2, 4, 8, 16, 32};
    drive_pd(1'b1);
    clk(STEP * (REF_PERIOD / CLK_PERIOD) - 8);
    check("R7", "no step before pacing interval", exp_q.size(), 5);
    clk(50);
    check("R7", "first step after pacing interval", exp_q.size(), 4);
    clk(RAMP_WAIT);
    check("R5", "all entry steps seen", exp_q.size(), 1);
    check("R4", "settled power-down ratio", exp_q[0], 32);
    clk(600);
    check("R4", "power-down ratio holds", exp_q.size(), 1);

    // R6: exit
    cur_req = "R6";
    clk(1);
    exp_q = '{32, 16, 8, 4, 2};
    drive_pd(1'b0);
    clk(RAMP_WAIT + 600);
    check("R6", "all exit steps seen", exp_q.size(), 1);
    check("R6", "back to base ratio", exp_q[0], 2);

    // R4 with base ratio 1
    cur_req = "R2";
    set_code(2'b11, 1, 2);
    cur_req = "R4";
    clk(1);
    exp_q = '{1, 2, 4, 8, 16};
    drive_pd(1'b1);
    clk(RAMP_WAIT + 600);
    check("R4", "ratio-1 power-down steps", exp_q.size(), 1);
    check("R4", "ratio-1 power-down ratio", exp_q[0], 16);
    cur_req = "R6";
    clk(1);
    exp_q = '{16, 8, 4, 2, 1};
    drive_pd(1'b0);
    clk(RAMP_WAIT + 600);
    check("R6", "ratio-1 exit steps", exp_q.size(), 1);

    // R11: reversal at level 2
    cur_req = "R2";
    set_code(2'b01, 4, 1);
    cur_req = "R11";
    clk(1);
    exp_q = '{4, 8, 16, 8, 4};
    drive_pd(1'b1);
    clk((2 * STEP + 64) * (REF_PERIOD / CLK_PERIOD));
    drive_pd(1'b0);
    clk(3 * STEP * (REF_PERIOD / CLK_PERIOD) + 800);
    check("R11", "reversed ramp sequence", exp_q.size(), 1);
    check("R11", "reversed ramp end ratio", exp_q[0], 4);

    // R8: disable in the middle of a high pulse
    cur_req = "R8";
    clk(1);
    mode = 2;
    exp_q = '{4};
    @(posedge fout);
    @(negedge clk2x) out_en = 1'b0;
    clk(8);
    r0 = rises;
    clk(200);
    check("R8", "no rising edge while disabled", rises, r0);
    @(negedge clk2x);
    check("R8", "fout parked low", int'(fout), 0);

    // R9: re-enable
    cur_req = "R9";
    @(negedge clk2x) out_en = 1'b1;
    clk(100);
    check("R9", "output restarted", int'(rises > r0), 1);
    clk(2);
    mode = 1;
    clk(100);
    check("R9", "ratio after restart", exp_q[0], 4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule